// File: doc/BRIEF.md
# Dual-Clock FIFO with Ready Flags

This block carries 18-bit words from a producer running on one free-running clock to a consumer running on another. The two clocks may be unrelated or may be the same net. It stores up to 512 words. The producer sees an input-ready flag in its own clock domain and the consumer sees an output-ready flag in its own. A half-full flag in the write domain warns the producer that half the capacity is in use.

The read side works in show-ahead fashion. The oldest unread word always sits in an output register. Output-ready high means that register holds a word not yet taken. A read taken while output-ready is high consumes that word. The register then refills with the next word in the same edge, or, if the FIFO is empty, output-ready drops and the taken word stays on the data pins. Each domain sees the other's pointer only through a two-register synchronizer clocked by its own clock. The pointer is gray-coded before it crosses. So a flag that depends on the far side reacts a fixed number of local edges late. A late flag is always on the safe side.

Top module: `dcfifo_ready`

## Requirements
- R1: While rst_ni is low and after it is released, in_ready_o is 1, out_ready_o is 0, half_full_o is 0 and rd_data_o is 0.
- R2: Every word presented with wr_en_i high at a write-clock rising edge where in_ready_o is high is stored. Words reach rd_data_o in the order written, with none lost or repeated.
- R3: A write attempted while in_ready_o is low has no effect: the word never appears on rd_data_o.
- R4: A read attempted while out_ready_o is low has no effect: it frees no space and consumes no later word.
- R5: in_ready_o falls at the write-clock edge that accepts the word bringing the unread count to 512. It never falls at an edge without a write request.
- R6: After a read is accepted, the space it frees makes in_ready_o and half_full_o respond at the third write-clock rising edge after that read edge, counting with coincident clocks.
- R7: With coincident clocks, a word written into an empty FIFO at edge k appears on rd_data_o, with out_ready_o going high, after edge k+3.
- R8: While out_ready_o is low, rd_data_o keeps the last word delivered (0 after reset).
- R9: A read accepted while out_ready_o is high loads the next word in the same edge if one has arrived. Otherwise it drops out_ready_o. Without a read, out_ready_o and rd_data_o hold.
- R10: half_full_o is registered in the write domain. It is high when accepted writes minus reads seen through the synchronizer is at least 256, and low when that count is below 256.
- R11: With unrelated clocks of different periods, R2, R3 and R4 still hold. in_ready_o is never high when 512 words are unread, and out_ready_o is never high when no word is unread.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk_i | input | 1 | Write-domain clock |
| rd_clk_i | input | 1 | Read-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 18 | Word to store |
| in_ready_o | output | 1 | Room available; writes accepted while high |
| half_full_o | output | 1 | At least half the capacity in use |
| rd_en_i | input | 1 | Read request (consumes the word on rd_data_o) |
| rd_data_o | output | 18 | Output register holding the oldest unread word |
| out_ready_o | output | 1 | rd_data_o holds a word not yet consumed |

## Verification
A corrupted pointer or synchronizer stage shows up at the ports within a few edges. The word in the output register differs from the expected stream at the next load. Alternatively, out_ready_o or in_ready_o switches one or more edges away from the cycle the requirements fix. With coincident clocks every flag and data value has an exact expected cycle. The behavioural model therefore catches an off-by-one latency or a miscount on the edge it occurs. An error in full or empty detection surfaces as a dropped, duplicated or foreign word once the FIFO is next drained. The unrelated-clock phase checks that flags stay on the safe side and that order holds when synchronizer sampling is irregular.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned WIDTH  = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int unsigned WIDTH = 18,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int unsigned AW = 9,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rd_gray_s_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wr_gray_o,
  output logic          in_ready_o,
  output logic          half_full_o
);
  logic [PW-1:0] ptr_q, ptr_d, gray_q, rd_bin, level_d;
  logic          ready_q, half_q;

  assign we_o    = wr_en_i & ready_q;
  assign ptr_d   = ptr_q + PW'(we_o);
  assign rd_bin  = PW'(gray2bin(32'(rd_gray_s_i)));
  // level never exceeds DEPTH, so the top bit alone marks full
  assign level_d = ptr_d - rd_bin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      gray_q  <= '0;
      ready_q <= 1'b1;
      half_q  <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      gray_q  <= PW'(bin2gray(32'(ptr_d)));
      ready_q <= ~level_d[AW];
      half_q  <= level_d[AW] | level_d[AW-1];
    end
  end

  assign waddr_o     = ptr_q[AW-1:0];
  assign wr_gray_o   = gray_q;
  assign in_ready_o  = ready_q;
  assign half_full_o = half_q;
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int unsigned AW    = 9,
  parameter int unsigned WIDTH = 18,
  localparam int unsigned PW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [PW-1:0]    wr_gray_s_i,
  input  logic [WIDTH-1:0] mem_rdata_i,
  output logic [AW-1:0]    raddr_o,
  output logic [PW-1:0]    cons_gray_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             out_ready_o
);
  logic [PW-1:0]    fetch_q, fetch_d, cons_q, cons_d, cons_gray_q, wr_bin;
  logic             valid_q, pop, load, mem_avail;
  logic [WIDTH-1:0] data_q;

  assign wr_bin    = PW'(gray2bin(32'(wr_gray_s_i)));
  assign mem_avail = (fetch_q != wr_bin);
  assign pop       = rd_en_i & valid_q;
  assign load      = mem_avail & (~valid_q | rd_en_i);
  assign fetch_d   = fetch_q + PW'(load);
  // space is released only when the consumer takes the word
  assign cons_d    = cons_q + PW'(pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q     <= '0;
      cons_q      <= '0;
      cons_gray_q <= '0;
      valid_q     <= 1'b0;
      data_q      <= '0;
    end else begin
      fetch_q     <= fetch_d;
      cons_q      <= cons_d;
      cons_gray_q <= PW'(bin2gray(32'(cons_d)));
      if (load) begin
        data_q  <= mem_rdata_i;
        valid_q <= 1'b1;
      end else if (pop) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign raddr_o     = fetch_q[AW-1:0];
  assign cons_gray_o = cons_gray_q;
  assign rd_data_o   = data_q;
  assign out_ready_o = valid_q;
endmodule

// File: rtl/dcfifo_ready.sv
module dcfifo_ready #(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned DEPTH       = 512,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              in_ready_o,
  output logic              half_full_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              out_ready_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic              mem_we;
  logic [AW-1:0]     waddr, raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic [PW-1:0]     wr_gray, wr_gray_s, cons_gray, cons_gray_s;

  dcf_wr_side #(.AW(AW)) i_wr (
    .clk_i       (wr_clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_gray_s_i (cons_gray_s),
    .we_o        (mem_we),
    .waddr_o     (waddr),
    .wr_gray_o   (wr_gray),
    .in_ready_o  (in_ready_o),
    .half_full_o (half_full_o)
  );

  dcf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) i_sync_w2r (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .d_i    (wr_gray),
    .q_o    (wr_gray_s)
  );

  dcf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) i_sync_r2w (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .d_i    (cons_gray),
    .q_o    (cons_gray_s)
  );

  dcf_mem #(.WIDTH(DATA_W), .DEPTH(DEPTH)) i_mem (
    .wclk_i  (wr_clk_i),
    .we_i    (mem_we),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  dcf_rd_side #(.AW(AW), .WIDTH(DATA_W)) i_rd (
    .clk_i       (rd_clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_i),
    .wr_gray_s_i (wr_gray_s),
    .mem_rdata_i (mem_rdata),
    .raddr_o     (raddr),
    .cons_gray_o (cons_gray),
    .rd_data_o   (rd_data_o),
    .out_ready_o (out_ready_o)
  );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int unsigned DATA_W = 18
) (
  input logic              wr_clk_i,
  input logic              rd_clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              in_ready_o,
  input logic              half_full_o,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              out_ready_o
);
  p_full_on_write_r5: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    $fell(in_ready_o) |-> $past(wr_en_i));

  p_half_needs_room_r10: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !half_full_o |-> in_ready_o);

  p_drop_on_read_r9: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $fell(out_ready_o) |-> $past(rd_en_i));

  p_hold_until_taken_r9: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (out_ready_o && !rd_en_i) |=> (out_ready_o && $stable(rd_data_o)));

  p_hold_when_empty_r8: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !out_ready_o |=> (out_ready_o || $stable(rd_data_o)));
endmodule

bind dcfifo_ready dcf_checker #(.DATA_W(DATA_W)) i_chk (
  .wr_clk_i    (wr_clk_i),
  .rd_clk_i    (rd_clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .in_ready_o  (in_ready_o),
  .half_full_o (half_full_o),
  .rd_en_i     (rd_en_i),
  .rd_data_o   (rd_data_o),
  .out_ready_o (out_ready_o)
);

// File: tb/test_dcfifo_ready.sv
module test_dcfifo_ready;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DEPTH = 512;

  logic        wr_clk = 1'b0, rd_clk_a = 1'b0, use_async = 1'b0;
  logic        rd_clk;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [17:0] wr_data = '0;
  logic        in_ready, half_full, out_ready;
  logic [17:0] rd_data;

  int n_vec = 0, n_fail = 0;
  logic [31:0] rs = 32'h2468_ace1;

  always #4ns wr_clk = ~wr_clk;
  always #5.5ns rd_clk_a = ~rd_clk_a;
  assign rd_clk = use_async ? rd_clk_a : wr_clk;

  dcfifo_ready i_dcfifo_ready (
    .wr_clk_i    (wr_clk),
    .rd_clk_i    (rd_clk),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .in_ready_o  (in_ready),
    .half_full_o (half_full),
    .rd_en_i     (rd_en),
    .rd_data_o   (rd_data),
    .out_ready_o (out_ready)
  );

  // behavioural model state
  logic [17:0] wq [$];
  int          wcnt, rcnt, lcnt;
  int          hw [$], hr [$];
  bit          m_ir, m_or, m_hf;
  logic [17:0] m_dout;

  function automatic logic [31:0] rnd_next(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic model_clear();
    wq.delete(); hw.delete(); hr.delete();
    wcnt = 0; rcnt = 0; lcnt = 0;
    for (int i = 0; i < 3; i++) begin hw.push_back(0); hr.push_back(0); end
    m_ir = 1'b1; m_or = 1'b0; m_hf = 1'b0; m_dout = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (4) @(negedge wr_clk);
    model_clear();
    rst_ni = 1'b1;
  endtask

  // one coincident-clock cycle: compare, drive, advance model to the next edge
  task automatic step(input bit we, input logic [17:0] d, input bit re);
    bit wf, rf;
    int w3, r3;
    chk(in_ready === m_ir, "R3 R5 R6 in_ready", 32'(in_ready), 32'(m_ir));
    chk(out_ready === m_or, "R4 R7 R9 out_ready", 32'(out_ready), 32'(m_or));
    chk(half_full === m_hf, "R6 R10 half_full", 32'(half_full), 32'(m_hf));
    chk(rd_data === m_dout, "R2 R3 R8 rd_data", 32'(rd_data), 32'(m_dout));
    wr_en = we; wr_data = d; rd_en = re;
    wf = we && m_ir;
    rf = re && m_or;
    if (wf) begin wq.push_back(d); wcnt++; end
    if (rf) rcnt++;
    w3 = hw[2]; r3 = hr[2];
    if (w3 > lcnt && (!m_or || re)) begin
      m_dout = wq[lcnt]; lcnt++; m_or = 1'b1;
    end else if (rf) begin
      m_or = 1'b0;
    end
    m_ir = (wcnt - r3) < DEPTH;
    m_hf = (wcnt - r3) >= DEPTH/2;
    hw.push_front(wcnt); hr.push_front(rcnt);
    void'(hw.pop_back()); void'(hr.pop_back());
    @(negedge wr_clk);
  endtask

  task automatic coincident_phase();
    use_async = 1'b0;
    do_reset();
    // R1 reset state
    chk(in_ready === 1'b1, "R1 in_ready", 32'(in_ready), 1);
    chk(out_ready === 1'b0, "R1 out_ready", 32'(out_ready), 0);
    chk(half_full === 1'b0, "R1 half_full", 32'(half_full), 0);
    chk(rd_data === 18'h0, "R1 rd_data", 32'(rd_data), 0);
    // R4: reads on an empty FIFO
    repeat (4) step(1'b0, '0, 1'b1);
    // R7: single word into empty FIFO, no read
    step(1'b1, 18'h2a5a5, 1'b0);
    repeat (6) step(1'b0, '0, 1'b0);
    // R9 drop then R8 hold with reads while empty
    step(1'b0, '0, 1'b1);
    repeat (5) step(1'b0, '0, 1'b1);
    // R9 advance through back-to-back words
    step(1'b1, 18'h00011, 1'b1);
    step(1'b1, 18'h00022, 1'b1);
    step(1'b1, 18'h00033, 1'b1);
    repeat (8) step(1'b0, '0, 1'b1);
    // R5 R3 R10: fill past capacity without reads
    for (int i = 0; i < 530; i++) step(1'b1, 18'(i * 7 + 5), 1'b0);
    // R6: single read then watch the ready flag return
    step(1'b0, '0, 1'b1);
    repeat (5) step(1'b1, 18'h3ffff, 1'b0);
    // drain
    for (int i = 0; i < 540; i++) step(1'b0, '0, 1'b1);
    // R2 mixed traffic
    for (int i = 0; i < 3000; i++) begin
      rs = rnd_next(rs);
      step(rs[3:0] < 4'd10, 18'(rs >> 8), rs[7:4] < 4'd8);
    end
    for (int i = 0; i < 600; i++) step(1'b0, '0, 1'b1);
  endtask

  // R11: unrelated clocks
  bit wdone;
  logic [31:0] rs_w = 32'h1357_9bdf, rs_r = 32'h0f0f_1234;

  task automatic async_writer();
    for (int i = 0; i < 4000; i++) begin
      @(negedge wr_clk);
      if (in_ready) chk((wcnt - rcnt) < DEPTH, "R11 in_ready high while full", 32'(wcnt - rcnt), DEPTH - 1);
      rs_w = rnd_next(rs_w);
      wr_en = rs_w[1:0] != 2'b00;
      wr_data = 18'(rs_w >> 7);
      if (wr_en && in_ready) begin wq.push_back(wr_data); wcnt++; end
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
    wdone = 1'b1;
  endtask

  task automatic async_reader();
    for (int i = 0; i < 20000; i++) begin
      @(negedge rd_clk);
      if (wdone && rcnt == wcnt) break;
      if (out_ready) begin
        chk(rcnt < wcnt, "R11 out_ready high while empty", 32'(rcnt), 32'(wcnt));
        if (rcnt < wq.size())
          chk(rd_data === wq[rcnt], "R2 R11 rd_data order", 32'(rd_data), 32'(wq[rcnt]));
      end
      rs_r = rnd_next(rs_r);
      rd_en = wdone ? 1'b1 : rs_r[0];
      if (rd_en && out_ready) rcnt++;
    end
    rd_en = 1'b0;
    chk(rcnt == wcnt, "R2 R11 words delivered", 32'(rcnt), 32'(wcnt));
  endtask

  task automatic async_phase();
    rst_ni = 1'b0;
    use_async = 1'b1;
    wdone = 1'b0;
    do_reset();
    fork
      async_writer();
      async_reader();
    join
  endtask

  initial begin
    model_clear();
    fork
      begin
        coincident_phase();
        async_phase();
      end
      begin
        repeat (150000) @(posedge wr_clk);
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule